// File: doc/BRIEF.md
# Message Object Transfer and Receive Allocation Engine

This block holds the message object store of a CAN controller and moves data between it and a small set of host-visible staging registers. The host loads staging values for the acceptance mask, the arbitration word, the message control word and two 32-bit data words. It then writes a command that names one object and selects which of these parts are moved and in which direction. A command runs for a fixed number of clocks, and a busy flag is raised for that time. Command bits can also clear an object's interrupt-pending flag, clear its new-data flag (on a read) or raise its transmit request (on a write).

On the receive side, a decoded frame (identifier, extended flag, length code and eight data bytes) is offered for one clock. The engine searches the objects from the lowest number upward for one that accepts the frame. Consecutive receive objects that share a filter form a FIFO that is closed by an object with the end-of-buffer flag. Per-object new-data and interrupt-pending flags are brought out as bit vectors. Bit timing and the serial bitstream are handled elsewhere.

Top module: `mobj_engine`

## Requirements
- R1: A host write to address 0 is a command: bits 23:16 are the command mask and bits 5:0 the object number. Only numbers 1 to NUM_OBJ start a transfer; 0 or a larger number leaves busy low and changes nothing.
- R2: Once a command is accepted, `busy` and bit 15 of address 0 read 1 for exactly BUSY_CYCLES (4) clocks. The transfer's effect is visible in the first cycle in which busy reads 0 again.
- R3: A command written while busy is high is ignored.
- R4: If mask bit 7 is 1 (write), the parts selected by mask bits 6 (acceptance mask, address 1), 5 (arbitration, address 2), 4 (control, address 3), 1 (data bytes 0-3, address 4) and 0 (data bytes 4-7, address 5) are copied from staging to the object. Parts that are not selected remain unchanged.
- R5: On a write, mask bit 3 clears the object's interrupt-pending flag (control bit 13) and mask bit 2 sets its transmit request (control bit 8). Both take effect after any control copy.
- R6: If mask bit 7 is 0 (read), the selected parts are copied from the object to staging, and staging parts that are not selected keep their values. Mask bit 3 clears the object's interrupt-pending flag and mask bit 2 clears its new-data flag (control bit 15). Staging receives the values from before these flags are cleared.
- R7: An object accepts a frame only if it is valid (arbitration bit 31), has receive direction (bit 29 = 0) and has an extended flag (bit 30) equal to the frame's. The identifier must also match: bits 28:18 for a standard frame or bits 28:0 for an extended frame. With use-mask (control bit 12) clear the match is exact. With it set, identifier positions whose acceptance-mask bit is 0 are ignored.
- R8: A frame is stored in the lowest-numbered accepting object whose new-data flag is clear. Storing writes the identifier into arbitration bits 28:0 (a standard identifier into bits 28:18, with bits 17:0 zero) and the length code into control bits 3:0. It also writes the data little-endian (byte 0 in bits 7:0 of address 4) and sets the new-data and interrupt-pending flags.
- R9: The search skips accepting objects whose new-data flag is set. It stops at the first accepting object that has end-of-buffer (control bit 7) set. If that object still holds new data, it is overwritten and its message-lost flag (control bit 14) is set. Objects above it are not considered.
- R10: A frame that no object takes under R8 or R9 is dropped without any state change.
- R11: Bit k of `newdat_vec` and `intpnd_vec` reflects object number k+1.
- R12: Reset clears all objects, all staging registers, busy and both vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address (0 command, 1 mask, 2 arbitration, 3 control, 4 data low, 5 data high) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (address 0 gives busy in bit 15) |
| busy | output | 1 | Transfer in progress |
| rx_valid | input | 1 | Received frame offered this cycle |
| rx_ext | input | 1 | Frame uses an extended identifier |
| rx_id | input | 29 | Frame identifier (standard identifier in bits 10:0) |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | 64 | Frame data, byte 0 in bits 7:0 |
| newdat_vec | output | NUM_OBJ | New-data flag per object |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending flag per object |

## Verification
The assertions assume that new-data flags rise only through a received frame or through a transfer that completes. They also assume that a frame never lands in the same clock edge that completes a transfer to the object it would fill. The bench meets the second assumption by offering each frame only after busy has returned low. It offers frames as single-cycle pulses, one at a time, and it writes staging registers only while no transfer is running, so every expected object value follows from the command order alone.

// File: rtl/mobj_pkg.sv
// Shared field positions and types for the message object engine.
// Assumes a 32-bit arbitration word, a 16-bit control word and 64 data bits.
package mobj_pkg;
    // Command mask bit positions
    localparam int CM_WR    = 7;
    localparam int CM_MSK   = 6;
    localparam int CM_ARB   = 5;
    localparam int CM_CTL   = 4;
    localparam int CM_CLRIP = 3;
    localparam int CM_TXND  = 2;
    localparam int CM_DLO   = 1;
    localparam int CM_DHI   = 0;

    // Arbitration word bit positions
    localparam int AR_VAL = 31;
    localparam int AR_XTD = 30;
    localparam int AR_DIR = 29;

    // Control word bit positions
    localparam int CT_ND   = 15;
    localparam int CT_LOST = 14;
    localparam int CT_IP   = 13;
    localparam int CT_UMSK = 12;
    localparam int CT_TXRQ = 8;
    localparam int CT_EOB  = 7;

    typedef struct packed {
        logic [31:0] msk;
        logic [31:0] arb;
        logic [15:0] ctl;
        logic [63:0] dat;
    } mobj_t;

    typedef enum logic [2:0] {
        HA_CMD = 3'd0,
        HA_MSK = 3'd1,
        HA_ARB = 3'd2,
        HA_CTL = 3'd3,
        HA_DLO = 3'd4,
        HA_DHI = 3'd5
    } haddr_e;
endpackage

// File: rtl/mobj_cmd_seq.sv
// Command sequencer: accepts a command when idle and the object number is
// in range, then holds busy for BUSY_CYCLES clocks. It pulses exec in the
// last busy cycle. Assumes BUSY_CYCLES >= 1.
module mobj_cmd_seq #(
    parameter int NUM_OBJ     = 32,
    parameter int OBJ_W       = 6,
    parameter int BUSY_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_wr,
    input  logic [7:0]                 cmd_mask_in,
    input  logic [OBJ_W-1:0]           cmd_obj_in,
    output logic                       busy,
    output logic                       exec,
    output logic [7:0]                 cmd_mask,
    output logic [$clog2(NUM_OBJ)-1:0] cmd_idx
);
    localparam int IDX_W = $clog2(NUM_OBJ);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [OBJ_W-1:0] MAX_OBJ = OBJ_W'(NUM_OBJ);

    logic [CNT_W-1:0] cnt;
    logic             obj_ok;
    logic [OBJ_W-1:0] obj_m1;

    // Range check of the requested object number
    assign obj_ok = (cmd_obj_in != '0) && (cmd_obj_in <= MAX_OBJ);
    assign obj_m1 = cmd_obj_in - 1'b1;
    assign exec   = busy && (cnt == '0);

    // Accept, count down and release the busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cmd_mask <= '0;
            cmd_idx  <= '0;
        end else if (!busy) begin
            if (cmd_wr && obj_ok) begin
                busy     <= 1'b1;
                cnt      <= CNT_W'(BUSY_CYCLES - 1);
                cmd_mask <= cmd_mask_in;
                cmd_idx  <= IDX_W'(obj_m1);
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mobj_rx_alloc.sv
// Receive allocator: compares an incoming frame with every object in
// parallel and picks the lowest object that is free or closes a FIFO.
// Assumes the object store is presented as a flat array.
module mobj_rx_alloc
    import mobj_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  mobj_t [NUM_OBJ-1:0]        objs,
    input  logic                       rx_ext,
    input  logic [28:0]                rx_id,
    output logic                       hit,
    output logic [$clog2(NUM_OBJ)-1:0] idx,
    output logic                       lost
);
    localparam int IDX_W = $clog2(NUM_OBJ);

    logic [NUM_OBJ-1:0] match;
    logic [NUM_OBJ-1:0] free;
    logic [NUM_OBJ-1:0] stop;
    logic [28:0]        got;

    // Align a standard identifier to the arbitration field
    assign got = rx_ext ? rx_id : {rx_id[10:0], 18'h0};

    for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
        logic [28:0] care;
        logic        unused_bits;

        // Identifier positions that take part in the comparison
        always_comb begin
            care = objs[k].ctl[CT_UMSK] ? objs[k].msk[28:0] : '1;
            if (!rx_ext) care[17:0] = '0;
        end

        assign match[k] = objs[k].arb[AR_VAL] && !objs[k].arb[AR_DIR] &&
                          (objs[k].arb[AR_XTD] == rx_ext) &&
                          (((objs[k].arb[28:0] ^ got) & care) == '0);
        assign free[k]  = match[k] && !objs[k].ctl[CT_ND];
        assign stop[k]  = free[k] || (match[k] && objs[k].ctl[CT_EOB]);
        assign unused_bits = ^{objs[k].msk[31:29], objs[k].ctl, objs[k].dat};
    end

    // Lowest-numbered stopping object wins
    always_comb begin
        idx = '0;
        for (int k = NUM_OBJ - 1; k >= 0; k--) begin
            if (stop[k]) idx = IDX_W'(k);
        end
        hit  = |stop;
        lost = hit && !free[idx];
    end
endmodule

// File: rtl/mobj_ram.sv
// Object store: register array updated by received frames and by
// completed host transfers. A transfer is applied after a frame in the
// same cycle, so its fields win on the target object.
module mobj_ram
    import mobj_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       exec,
    input  logic [7:0]                 cmd_mask,
    input  logic [$clog2(NUM_OBJ)-1:0] cmd_idx,
    input  mobj_t                      stage,
    input  logic                       rx_store,
    input  logic [$clog2(NUM_OBJ)-1:0] rx_idx,
    input  logic                       rx_lost,
    input  logic                       rx_ext,
    input  logic [28:0]                rx_id,
    input  logic [3:0]                 rx_dlc,
    input  logic [63:0]                rx_data,
    output mobj_t [NUM_OBJ-1:0]        objs,
    output logic [NUM_OBJ-1:0]         newdat_vec,
    output logic [NUM_OBJ-1:0]         intpnd_vec
);
    // Frame storage followed by transfer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_OBJ; k++) objs[k] <= '0;
        end else begin
            if (rx_store) begin
                objs[rx_idx].arb[28:0]  <= rx_ext ? rx_id : {rx_id[10:0], 18'h0};
                objs[rx_idx].ctl[3:0]   <= rx_dlc;
                objs[rx_idx].ctl[CT_ND] <= 1'b1;
                objs[rx_idx].ctl[CT_IP] <= 1'b1;
                objs[rx_idx].dat        <= rx_data;
                if (rx_lost) objs[rx_idx].ctl[CT_LOST] <= 1'b1;
            end
            if (exec) begin
                if (cmd_mask[CM_WR]) begin
                    if (cmd_mask[CM_MSK]) objs[cmd_idx].msk        <= stage.msk;
                    if (cmd_mask[CM_ARB]) objs[cmd_idx].arb        <= stage.arb;
                    if (cmd_mask[CM_CTL]) objs[cmd_idx].ctl        <= stage.ctl;
                    if (cmd_mask[CM_DLO]) objs[cmd_idx].dat[31:0]  <= stage.dat[31:0];
                    if (cmd_mask[CM_DHI]) objs[cmd_idx].dat[63:32] <= stage.dat[63:32];
                    if (cmd_mask[CM_CLRIP]) objs[cmd_idx].ctl[CT_IP] <= 1'b0;
                    if (cmd_mask[CM_TXND])  objs[cmd_idx].ctl[CT_TXRQ] <= 1'b1;
                end else begin
                    if (cmd_mask[CM_CLRIP]) objs[cmd_idx].ctl[CT_IP] <= 1'b0;
                    if (cmd_mask[CM_TXND])  objs[cmd_idx].ctl[CT_ND] <= 1'b0;
                end
            end
        end
    end

    // Flag vectors gathered from the array
    always_comb begin
        for (int k = 0; k < NUM_OBJ; k++) begin
            newdat_vec[k] = objs[k].ctl[CT_ND];
            intpnd_vec[k] = objs[k].ctl[CT_IP];
        end
    end
endmodule

// File: rtl/mobj_engine.sv
// Top of the message object engine: host staging registers, command
// decode and readback, and the wiring of sequencer, allocator and store.
// Assumes the host leaves staging untouched while busy is high.
module mobj_engine
    import mobj_pkg::*;
#(
    parameter int NUM_OBJ     = 32,
    parameter int OBJ_W       = 6,
    parameter int BUSY_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [2:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               busy,
    input  logic               rx_valid,
    input  logic               rx_ext,
    input  logic [28:0]        rx_id,
    input  logic [3:0]         rx_dlc,
    input  logic [63:0]        rx_data,
    output logic [NUM_OBJ-1:0] newdat_vec,
    output logic [NUM_OBJ-1:0] intpnd_vec
);
    localparam int IDX_W = $clog2(NUM_OBJ);

    mobj_t                stage;
    mobj_t                sel_obj;
    mobj_t [NUM_OBJ-1:0]  objs;
    logic                 cmd_wr;
    logic                 exec;
    logic [7:0]           cmd_mask;
    logic [IDX_W-1:0]     cmd_idx;
    logic                 rx_hit;
    logic [IDX_W-1:0]     rx_idx;
    logic                 rx_lost;

    assign cmd_wr  = host_wr_en && (haddr_e'(host_addr) == HA_CMD);
    assign sel_obj = objs[cmd_idx];

    mobj_cmd_seq #(
        .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .cmd_mask_in(host_wdata[23:16]), .cmd_obj_in(host_wdata[OBJ_W-1:0]),
        .busy(busy), .exec(exec), .cmd_mask(cmd_mask), .cmd_idx(cmd_idx)
    );

    mobj_rx_alloc #(.NUM_OBJ(NUM_OBJ)) u_alloc (
        .objs(objs), .rx_ext(rx_ext), .rx_id(rx_id),
        .hit(rx_hit), .idx(rx_idx), .lost(rx_lost)
    );

    mobj_ram #(.NUM_OBJ(NUM_OBJ)) u_ram (
        .clk(clk), .rst_n(rst_n), .exec(exec), .cmd_mask(cmd_mask),
        .cmd_idx(cmd_idx), .stage(stage), .rx_store(rx_valid && rx_hit),
        .rx_idx(rx_idx), .rx_lost(rx_lost), .rx_ext(rx_ext), .rx_id(rx_id),
        .rx_dlc(rx_dlc), .rx_data(rx_data), .objs(objs),
        .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec)
    );

    // Staging registers: loaded by read transfers or by host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (exec && !cmd_mask[CM_WR]) begin
            if (cmd_mask[CM_MSK]) stage.msk        <= sel_obj.msk;
            if (cmd_mask[CM_ARB]) stage.arb        <= sel_obj.arb;
            if (cmd_mask[CM_CTL]) stage.ctl        <= sel_obj.ctl;
            if (cmd_mask[CM_DLO]) stage.dat[31:0]  <= sel_obj.dat[31:0];
            if (cmd_mask[CM_DHI]) stage.dat[63:32] <= sel_obj.dat[63:32];
        end else if (host_wr_en) begin
            case (haddr_e'(host_addr))
                HA_MSK:  stage.msk        <= host_wdata;
                HA_ARB:  stage.arb        <= host_wdata;
                HA_CTL:  stage.ctl        <= host_wdata[15:0];
                HA_DLO:  stage.dat[31:0]  <= host_wdata;
                HA_DHI:  stage.dat[63:32] <= host_wdata;
                default: ;
            endcase
        end
    end

    // Host readback multiplexer
    always_comb begin
        case (haddr_e'(host_addr))
            HA_CMD:  host_rdata = {16'h0, busy, 15'h0};
            HA_MSK:  host_rdata = stage.msk;
            HA_ARB:  host_rdata = stage.arb;
            HA_CTL:  host_rdata = {16'h0, stage.ctl};
            HA_DLO:  host_rdata = stage.dat[31:0];
            HA_DHI:  host_rdata = stage.dat[63:32];
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mobj_engine_chk.sv
// Property checker for the message object engine, bound to the top.
// Assumes a synchronous active-low reset held for at least one clock.
module mobj_engine_chk #(
    parameter int NUM_OBJ     = 32,
    parameter int BUSY_CYCLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               cmd_wr,
    input logic               exec,
    input logic               rx_valid,
    input logic [NUM_OBJ-1:0] newdat_vec,
    input logic [NUM_OBJ-1:0] intpnd_vec
);
    int bcnt;

    // Length of the current or just-finished busy window
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bcnt != 0) |-> (bcnt == BUSY_CYCLES));

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < BUSY_CYCLES));

    p_start_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr));

    p_single_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(newdat_vec & ~$past(newdat_vec)) <= 1);

    p_nd_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(newdat_vec & ~$past(newdat_vec))) |-> ($past(rx_valid) || $past(exec)));

    p_ip_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(intpnd_vec) & ~intpnd_vec)) |-> $past(exec));
endmodule

bind mobj_engine mobj_engine_chk #(.NUM_OBJ(NUM_OBJ), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_wr(cmd_wr), .exec(exec),
    .rx_valid(rx_valid), .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec)
);

// File: tb/mobj_engine_tb_top.sv
// Self-checking bench: a table of received frames with expected flag
// vectors, followed by directed transfer and corner-case tests.
module mobj_engine_tb_top;
    import mobj_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_en;
    logic [2:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        busy;
    logic        rx_valid;
    logic        rx_ext;
    logic [28:0] rx_id;
    logic [3:0]  rx_dlc;
    logic [63:0] rx_data;
    logic [31:0] newdat_vec;
    logic [31:0] intpnd_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mobj_engine dut_i (.*);

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic [31:0] vec;
    } rxv_t;

    // Frames applied in order to the configured objects, with cumulative flags
    localparam rxv_t RXV [9] = '{
        '{1'b0, 29'h123,     32'h01},   // R8 first FIFO slot
        '{1'b0, 29'h12F,     32'h03},   // R7 masked bits ignored
        '{1'b0, 29'h200,     32'h03},   // R10 no match
        '{1'b1, 29'h1ABCDE0, 32'h13},   // R7 extended exact
        '{1'b0, 29'h300,     32'h13},   // R7 transmit / invalid objects refuse
        '{1'b1, 29'h1ABCDE1, 32'h13},   // R7 exact mismatch
        '{1'b0, 29'h125,     32'h17},   // R9 fills end-of-buffer slot
        '{1'b0, 29'h126,     32'h17},   // R9 overwrite with lost
        '{1'b1, 29'h4800000, 32'h17}    // R7 extended flag mismatch
    };

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic hw(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hr(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic cmd(logic [7:0] m, logic [5:0] o);
        hw(HA_CMD, {8'h0, m, 10'h0, o});
        while (busy) @(negedge clk);
    endtask

    task automatic stage(logic [31:0] m, logic [31:0] a, logic [31:0] c,
                         logic [31:0] lo, logic [31:0] hi);
        hw(HA_MSK, m); hw(HA_ARB, a); hw(HA_CTL, c); hw(HA_DLO, lo); hw(HA_DHI, hi);
    endtask

    task automatic frame(logic e, logic [28:0] id, logic [63:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_ext = e; rx_id = id; rx_dlc = 4'd8; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        int cnt;
        rst_n = 1'b0; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
        rx_valid = 1'b0; rx_ext = 1'b0; rx_id = '0; rx_dlc = '0; rx_data = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 newdat", newdat_vec, 32'h0);
        chk("R12 intpnd", intpnd_vec, 32'h0);
        chk("R12 busy", {31'h0, busy}, 32'h0);
        for (int a = 1; a < 6; a++) begin
            hr(3'(a), v);
            chk("R12 staging", v, 32'h0);
        end
        rst_n = 1'b1;

        // R1 out-of-range object numbers start nothing
        hw(HA_CMD, {8'h0, 8'h90, 10'h0, 6'd0});
        chk("R1 obj0 busy", {31'h0, busy}, 32'h0);
        hw(HA_CMD, {8'h0, 8'h90, 10'h0, 6'd33});
        chk("R1 obj33 busy", {31'h0, busy}, 32'h0);

        // Object setup for the receive table
        stage(32'h1FC00000, 32'h84800000, 32'h1000, 0, 0); cmd(8'hF3, 1);
        cmd(8'hF3, 2);
        stage(32'h1FC00000, 32'h84800000, 32'h1080, 0, 0); cmd(8'hF3, 3);
        stage(32'h1FC00000, 32'hC1ABCDE0, 32'h0080, 0, 0); cmd(8'hF3, 5);
        stage(32'h1FC00000, 32'hAC000000, 32'h0000, 0, 0); cmd(8'hF3, 6);
        stage(32'h5A5A5A5A, 32'h0C000000, 32'h0000, 0, 0); cmd(8'hF3, 7);

        for (int i = 0; i < 9; i++) begin
            frame(RXV[i].ext, RXV[i].id,
                  (i == 7) ? 64'hA1A2A3A4A5A6A7A8 : {32'h0, 32'(i)});
            chk($sformatf("R8 R9 R10 table %0d newdat", i), newdat_vec, RXV[i].vec);
            chk($sformatf("R11 table %0d intpnd", i), intpnd_vec, RXV[i].vec);
        end

        // R9 overwritten end-of-buffer object, read with both clears (R6)
        cmd(8'h3F, 3);
        hr(HA_CTL, v); chk("R9 lost ctl", v, 32'hF088);
        hr(HA_ARB, v); chk("R8 stored id", v, 32'h84980000);
        hr(HA_DLO, v); chk("R8 data low", v, 32'hA5A6A7A8);
        hr(HA_DHI, v); chk("R8 data high", v, 32'hA1A2A3A4);
        hr(HA_MSK, v); chk("R6 unselected mask", v, 32'h5A5A5A5A);
        chk("R6 flags cleared", newdat_vec, 32'h13);
        chk("R6 intpnd cleared", intpnd_vec, 32'h13);
        cmd(8'h20, 2);
        hr(HA_ARB, v); chk("R7 masked id stored", v, 32'h84BC0000);

        // R8 lowest free object preferred
        cmd(8'h04, 1);
        chk("R6 newdat only", newdat_vec, 32'h12);
        chk("R6 intpnd kept", intpnd_vec, 32'h13);
        frame(1'b0, 29'h127, 64'h0);
        chk("R8 lowest free", newdat_vec, 32'h13);

        // R4 selective write
        stage(32'h11111111, 32'hA0000155, 32'h0, 32'hD0D0D0D0, 32'hE0E0E0E0);
        cmd(8'hF3, 10);
        hw(HA_ARB, 32'hA0000999); hw(HA_DLO, 32'h12345678); hw(HA_DHI, 32'h9ABCDEF0);
        cmd(8'h82, 10);
        hw(HA_ARB, 0); hw(HA_DLO, 0); hw(HA_DHI, 0);
        cmd(8'h23, 10);
        hr(HA_ARB, v); chk("R4 arb kept", v, 32'hA0000155);
        hr(HA_DLO, v); chk("R4 data low written", v, 32'h12345678);
        hr(HA_DHI, v); chk("R4 data high kept", v, 32'hE0E0E0E0);

        // R2 busy window length and readback
        hw(HA_CMD, {8'h0, 8'h00, 10'h0, 6'd10});
        cnt = 0;
        while (busy && cnt < 50) begin cnt++; @(negedge clk); end
        chk("R2 busy cycles", 32'(cnt), 32'd4);
        hw(HA_CMD, {8'h0, 8'h00, 10'h0, 6'd10});
        hr(HA_CMD, v); chk("R2 busy bit", v, 32'h8000);
        while (busy) @(negedge clk);
        hr(HA_CMD, v); chk("R2 idle bit", v, 32'h0);

        // R3 command during busy ignored
        hw(HA_CTL, 32'h2000);
        hw(HA_CMD, {8'h0, 8'h00, 10'h0, 6'd10});
        hw(HA_CMD, {8'h0, 8'h90, 10'h0, 6'd11});
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R3 ignored command", intpnd_vec, 32'h13);

        // R5 write side effects after control copy
        hw(HA_CTL, 32'h2003);
        cmd(8'h9C, 10);
        chk("R5 intpnd cleared", intpnd_vec, 32'h13);
        hw(HA_CTL, 0);
        cmd(8'h10, 10);
        hr(HA_CTL, v); chk("R5 txrqst set", v, 32'h0103);

        // R11 bit position of object 10
        hw(HA_CTL, 32'h2000);
        cmd(8'h90, 10);
        chk("R11 object 10 bit", intpnd_vec, 32'h213);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule